// File: doc/BRIEF.md
# Disk Write Serializer with Buffer Handshake

This block turns bytes from a host into a serial bit stream for a disk drive. Each bit occupies one bit cell of `bit_len` clocks and bytes leave most significant bit first. A single holding buffer sits between the host and the shift register. The host sees two flags: `buf_ready` shows that the buffer can take another byte, and `no_underrun` stays high as long as every byte boundary found a fresh byte waiting.

Two mode switches, `mode_wr` and `mode_chk`, select the block's phase. There are four named phases:

- IDLE is the reading or quiet phase, with both switches low.
- SENSE is the write-protect check, entered whenever `mode_chk` is high. In this phase the `sense_in` line is shifted into the register on every clock.
- WRITE is entered only by the transition SENSE to WRITE, when the switches read `mode_wr`=1, `mode_chk`=0 while the block is in SENSE. Any other path to that switch setting leaves the phase unchanged.
- DONE follows WRITE when a byte boundary finds no new byte (the transition WRITE to DONE). The drive write stops there instead of repeating stale data.

The full set of transitions is:

- any non-write phase to SENSE when `mode_chk`=1;
- any non-write phase to IDLE when both switches are low;
- SENSE to WRITE as described above;
- WRITE to DONE on underrun.

While in WRITE the switches have no effect.

Top module: `disk_write_serializer`

## Requirements
- R1: After reset `wr_active`=0, `wr_bit`=0, `buf_ready`=1, `no_underrun`=1 and `sense_byte`=0.
- R2: In SENSE (`mode_chk`=1, no write running) each clock moves the register one place toward bit 0 and places `sense_in` in bit 7. After eight clocks, bit 7 holds the newest sample and bit 0 the oldest. `sense_byte` shows the register only in SENSE and reads 0 in every other phase.
- R3: WRITE is entered only from SENSE with `mode_wr`=1, `mode_chk`=0. With that switch setting in IDLE or DONE, `wr_active` stays 0.
- R4: On entering WRITE, the register loads the held byte and `buf_ready` and `no_underrun` are both set to 1. `wr_active` goes to 1 on the clock after the switches are sampled.
- R5: Bits leave most significant bit first. Each bit is shown on `wr_bit` for exactly `bit_len` clocks, starting the cycle `wr_active` rises.
- R6: A host strobe (`host_wr`=1) is taken only when `mode_wr`=1 and `mode_chk`=1. It stores `host_byte` and clears `buf_ready`. At any other switch setting the strobe is ignored and `buf_ready` keeps its value.
- R7: At a byte boundary with `buf_ready`=0, the held byte follows with no gap and `buf_ready` returns to 1.
- R8: At a byte boundary with `buf_ready`=1, `no_underrun` is cleared and `wr_active` drops to 0. No further bits are sent.
- R9: While WRITE is running, changes of `mode_wr` and `mode_chk` do not change the phase.
- R10: `wr_bit` is 0 whenever `wr_active` is 0.
- R11: After a write has ended, the sequence SENSE then write-load starts a new write with `no_underrun` back at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_len | input | BLW (6) | Clocks per bit cell, at least 1 |
| host_byte | input | DW (8) | Byte offered by the host |
| host_wr | input | 1 | Host data strobe |
| mode_wr | input | 1 | Write-select mode switch |
| mode_chk | input | 1 | Sense/load mode switch |
| sense_in | input | 1 | Write-protect sense line from the drive |
| wr_bit | output | 1 | Serial write data to the drive |
| wr_active | output | 1 | Drive write in progress |
| buf_ready | output | 1 | Holding buffer can take a byte |
| no_underrun | output | 1 | Low once a byte boundary found no byte |
| sense_byte | output | DW (8) | Register contents during SENSE, else 0 |

## Verification
Each change of switches or strobe takes effect on the next rising edge, so flags and phase are checked one clock after the stimulus, on the falling edge. The serial stream is due from the first cycle `wr_active` is high: bit k fills cycles k·`bit_len` to (k+1)·`bit_len`−1 counted from that cycle. The monitor compares `wr_bit` on every one of those cycles against the bit queued by the driver. When `wr_active` falls, the run length must equal `bit_len` times the number of queued bits. The boundary flag checks are placed a few cycles past each computed boundary, so their timing does not depend on process order.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SENSE = 2'd1,
        PH_WRITE = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;
endpackage

// File: rtl/dws_phase_fsm.sv
module dws_phase_fsm
    import dws_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_wr,
    input  logic   mode_chk,
    input  logic   underrun_evt,
    output phase_t phase,
    output logic   start_evt
);
    phase_t phase_q;
    phase_t phase_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WRITE: begin
                // switches locked out while the drive is writing
                if (underrun_evt) phase_d = PH_DONE;
            end
            PH_SENSE: begin
                if (mode_chk)      phase_d = PH_SENSE;
                else if (mode_wr)  phase_d = PH_WRITE;
                else               phase_d = PH_IDLE;
            end
            PH_IDLE, PH_DONE: begin
                if (mode_chk)      phase_d = PH_SENSE;
                else if (!mode_wr) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phase     = phase_q;
        start_evt = (phase_q == PH_SENSE) && mode_wr && !mode_chk;
    end
endmodule

// File: rtl/dws_cell_timer.sv
module dws_cell_timer #(
    parameter int BLW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [BLW-1:0] bit_len,
    output logic           cell_end
);
    localparam int CW = BLW + 1;

    logic [BLW-1:0] cyc_q;
    logic [CW-1:0]  cyc_next;

    assign cyc_next = {1'b0, cyc_q} + CW'(1);
    assign cell_end = run && (cyc_next >= {1'b0, bit_len});

    always_ff @(posedge clk) begin
        if (!rst_n || !run || cell_end) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_next[BLW-1:0];
        end
    end
endmodule

// File: rtl/dws_shift_path.sv
module dws_shift_path
    import dws_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic          start_evt,
    input  logic          cell_end,
    input  logic          strobe_ok,
    input  logic [DW-1:0] host_byte,
    input  logic          sense_in,
    output logic [DW-1:0] shreg,
    output logic          ready,
    output logic          ok,
    output logic          underrun_evt
);
    localparam int NW = $clog2(DW + 1);

    logic [DW-1:0] hold_q;
    logic [NW-1:0] left_q;
    logic          last_bit;

    assign last_bit     = (left_q == NW'(1));
    assign underrun_evt = (phase == PH_WRITE) && cell_end && last_bit && ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            hold_q <= '0;
            left_q <= '0;
            ready  <= 1'b1;
            ok     <= 1'b1;
        end else begin
            if (start_evt) begin
                shreg  <= hold_q;
                left_q <= NW'(DW);
                ready  <= 1'b1;
                ok     <= 1'b1;
            end else if (phase == PH_SENSE) begin
                shreg <= {sense_in, shreg[DW-1:1]};
            end else if (phase == PH_WRITE && cell_end) begin
                if (last_bit) begin
                    if (!ready) begin
                        shreg  <= hold_q;
                        left_q <= NW'(DW);
                    end else begin
                        shreg  <= shreg << 1;
                        ok     <= 1'b0;
                        left_q <= '0;
                    end
                    ready <= 1'b1;
                end else begin
                    shreg  <= shreg << 1;
                    left_q <= left_q - NW'(1);
                end
            end
            // host strobe overrides a boundary in the same cycle
            if (strobe_ok) begin
                hold_q <= host_byte;
                ready  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/disk_write_serializer.sv
module disk_write_serializer
    import dws_pkg::*;
#(
    parameter int BLW = 6,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [BLW-1:0] bit_len,
    input  logic [DW-1:0]  host_byte,
    input  logic           host_wr,
    input  logic           mode_wr,
    input  logic           mode_chk,
    input  logic           sense_in,
    output logic           wr_bit,
    output logic           wr_active,
    output logic           buf_ready,
    output logic           no_underrun,
    output logic [DW-1:0]  sense_byte
);
    phase_t        phase_q;
    logic          start_evt;
    logic          underrun_evt;
    logic          cell_end;
    logic          strobe_ok;
    logic [DW-1:0] shreg;

    assign strobe_ok = host_wr && mode_wr && mode_chk;

    dws_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_chk     (mode_chk),
        .underrun_evt (underrun_evt),
        .phase        (phase_q),
        .start_evt    (start_evt)
    );

    dws_cell_timer #(.BLW(BLW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (phase_q == PH_WRITE),
        .bit_len  (bit_len),
        .cell_end (cell_end)
    );

    dws_shift_path #(.DW(DW)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase_q),
        .start_evt    (start_evt),
        .cell_end     (cell_end),
        .strobe_ok    (strobe_ok),
        .host_byte    (host_byte),
        .sense_in     (sense_in),
        .shreg        (shreg),
        .ready        (buf_ready),
        .ok           (no_underrun),
        .underrun_evt (underrun_evt)
    );

    always_comb begin
        wr_active  = (phase_q == PH_WRITE);
        wr_bit     = wr_active && shreg[DW-1];
        sense_byte = (phase_q == PH_SENSE) ? shreg : '0;
    end
endmodule

// File: rtl/dws_checker.sv
module dws_checker
    import dws_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   mode_wr,
    input logic   mode_chk,
    input logic   host_wr,
    input logic   wr_bit,
    input logic   wr_active,
    input logic   buf_ready,
    input logic   no_underrun,
    input phase_t phase,
    input logic   cell_end
);
    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_active |-> !wr_bit);

    assert_start_from_sense_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_active) |-> $past(phase == PH_SENSE));

    assert_no_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |=> !wr_active);

    assert_entry_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_active) |-> (buf_ready && no_underrun));

    assert_strobe_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && mode_wr && mode_chk) |=> !buf_ready);

    assert_bit_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && !cell_end) |=> (!wr_active || $stable(wr_bit)));

    assert_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && !cell_end) |=> wr_active);

    assert_underrun_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_underrun) |-> !wr_active);
endmodule

bind disk_write_serializer dws_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_chk    (mode_chk),
    .host_wr     (host_wr),
    .wr_bit      (wr_bit),
    .wr_active   (wr_active),
    .buf_ready   (buf_ready),
    .no_underrun (no_underrun),
    .phase       (phase_q),
    .cell_end    (cell_end)
);

// File: tb/sim_disk_write_serializer.sv
module sim_disk_write_serializer;
    localparam int CLK_P = 10;
    localparam int BLW   = 6;
    localparam int DW    = 8;
    localparam int L     = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [BLW-1:0] bit_len = BLW'(L);
    logic [DW-1:0]  host_byte = '0;
    logic           host_wr = 1'b0;
    logic           mode_wr = 1'b0;
    logic           mode_chk = 1'b0;
    logic           sense_in = 1'b0;
    logic           wr_bit;
    logic           wr_active;
    logic           buf_ready;
    logic           no_underrun;
    logic [DW-1:0]  sense_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    disk_write_serializer #(.BLW(BLW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .host_byte(host_byte),
        .host_wr(host_wr), .mode_wr(mode_wr), .mode_chk(mode_chk),
        .sense_in(sense_in), .wr_bit(wr_bit), .wr_active(wr_active),
        .buf_ready(buf_ready), .no_underrun(no_underrun), .sense_byte(sense_byte)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: queue the bits a byte must produce
    task automatic push_byte(input logic [DW-1:0] b);
        for (int i = DW - 1; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // monitor side: one cell per L cycles, compared every cycle
    initial begin
        int cnt = 0;
        int popped = 0;
        bit cur = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && wr_active) begin
                if (cnt % L == 0) begin
                    if (exp_q.size() == 0) begin
                        check("R8 extra bit", 1, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        popped++;
                    end
                end
                check("R5 wr_bit", int'(wr_bit), int'(cur));
                cnt++;
            end else begin
                if (cnt != 0) check("R8 run length", cnt, popped * L);
                cnt = 0;
                popped = 0;
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic wait_done();
        for (int i = 0; i < 200 && wr_active; i++) @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] pat;
        pat = 8'b0100_1101;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wr_active", wr_active, 0);
        check("R1 wr_bit", wr_bit, 0);
        check("R1 buf_ready", buf_ready, 1);
        check("R1 no_underrun", no_underrun, 1);
        check("R1 sense_byte", sense_byte, 0);
        #1;
        // R6 strobe ignored in IDLE
        host_byte = 8'hFF; host_wr = 1'b1;
        step(); host_wr = 1'b0;
        @(negedge clk);
        check("R6 ignored strobe", buf_ready, 1);
        #1;
        // R3 write-load from IDLE does nothing
        mode_wr = 1'b1;
        repeat (4) step();
        check("R3 no start from idle", wr_active, 0);
        check("R10 idle wr_bit", wr_bit, 0);
        // R2 sense shifting
        mode_wr = 1'b0; mode_chk = 1'b1;
        step();
        for (int i = 0; i < DW; i++) begin
            sense_in = pat[i];
            step();
        end
        check("R2 sense_byte", sense_byte, int'(pat));
        // R6 strobe accepted with both switches high
        mode_wr = 1'b1; host_byte = 8'hA5; host_wr = 1'b1;
        step(); host_wr = 1'b0;
        check("R6 strobe clears ready", buf_ready, 0);
        // R4 enter write
        mode_chk = 1'b0;
        push_byte(8'hA5);
        step();
        check("R4 wr_active", wr_active, 1);
        check("R4 buf_ready", buf_ready, 1);
        check("R4 no_underrun", no_underrun, 1);
        check("R2 sense_byte zero in write", sense_byte, 0);
        repeat (3) step();
        // R9 switch change during write, then second byte
        mode_chk = 1'b1; host_byte = 8'h3C; host_wr = 1'b1;
        push_byte(8'h3C);
        step(); host_wr = 1'b0;
        check("R9 still writing", wr_active, 1);
        check("R6 second strobe", buf_ready, 0);
        mode_wr = 1'b0; mode_chk = 1'b0;
        repeat (22) step();
        check("R7 ready after boundary", buf_ready, 1);
        check("R9 write continues", wr_active, 1);
        wait_done();
        #1;
        check("R8 no_underrun cleared", no_underrun, 0);
        check("R8 ready stays", buf_ready, 1);
        check("R10 wr_bit low", wr_bit, 0);
        check("R8 queue drained", exp_q.size(), 0);
        // R3 write-load from DONE does nothing
        mode_wr = 1'b1;
        repeat (4) step();
        check("R3 no start from done", wr_active, 0);
        // R11 restart through SENSE
        mode_chk = 1'b1; host_byte = 8'h81; host_wr = 1'b1;
        step(); host_wr = 1'b0;
        mode_chk = 1'b0;
        push_byte(8'h81);
        step();
        check("R11 restarted", wr_active, 1);
        check("R11 no_underrun set", no_underrun, 1);
        wait_done();
        #1;
        check("R11 ended", wr_active, 0);
        check("R8 queue drained again", exp_q.size(), 0);
        repeat (2) step();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule